// File: doc/BRIEF.md
# I/O Port Window Decoder

This block watches the low eight address lines of an 8-bit processor bus during I/O cycles and picks out a window of port addresses that belongs to one peripheral. A base address and a don't-care mask come in as static configuration inputs and take the place of switches or jumpers on a board. Each set mask bit removes one address bit from the comparison. A mask made of a run of low-order ones therefore selects an aligned block of 1, 2, 4 and so on up to 256 ports.

The raw comparator result is gated only by an active-low enable input. The read and write selects add two more conditions. The cycle must be an I/O request with the machine-cycle-one line high, so an interrupt acknowledge never produces a strobe. Exactly one of the read and write lines must also be low. If both are low inside the window, both selects stay off and a bus-error flag rises. The masked low address bits come out as an offset, so the peripheral can pick one of up to eight registers. A configuration-error flag reports a mask that is not a contiguous low-order run, and decoding still proceeds bit by bit in that case. Every output is combinational and has no latency.

Top module: `io_port_decoder`

## Requirements
- R1: `match_n` is low exactly when `en_n` is low and every address bit whose mask bit is 0 equals the corresponding base bit.
- R2: While `en_n` is high, `match_n` is high and both read and write selects are inactive, whatever the address.
- R3: A mask bit of 1 makes that address bit don't-care. With mask 0x07 and base 0x08, ports 0x08 to 0x0F match, and 0x07 and 0x10 do not.
- R4: With mask 0x00, exactly one port address, equal to the base, matches.
- R5: `rd_sel` is 1 exactly when there is a match, `iorq_n`=0, `m1_n`=1, `rd_n`=0 and `wr_n`=1.
- R6: `wr_sel` is 1 exactly when there is a match, `iorq_n`=0, `m1_n`=1, `wr_n`=0 and `rd_n`=1.
- R7: With `iorq_n` high (a memory or idle cycle), neither select asserts, even if the address matches.
- R8: With `iorq_n` and `m1_n` both low (interrupt acknowledge), neither select asserts, even with a matching address and `rd_n` or `wr_n` low.
- R9: When `rd_n` and `wr_n` are both low during a matching I/O cycle, both selects are 0 and `bus_err` is 1. Otherwise `bus_err` is 0, so `rd_sel` and `wr_sel` are never 1 together.
- R10: `rd_sel_n` and `wr_sel_n` are always the inverses of `rd_sel` and `wr_sel`.
- R11: `offset[k]` equals `addr[k] & cfg_mask[k]` for k = 0..2, independent of the bus strobes.
- R12: `cfg_err` is 1 exactly when `cfg_mask` is not of the form 2^k-1. Even then, matching follows R1 bit by bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 8 | Low address bits of the bus |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Machine cycle one, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| en_n | input | 1 | Decoder enable, active low |
| cfg_base | input | 8 | Configured base address |
| cfg_mask | input | 8 | Don't-care mask, 1 = bit ignored |
| match_n | output | 1 | Raw window match, active low |
| rd_sel | output | 1 | Read select, active high |
| wr_sel | output | 1 | Write select, active high |
| rd_sel_n | output | 1 | Read select, active low |
| wr_sel_n | output | 1 | Write select, active low |
| offset | output | 3 | Masked low address bits |
| cfg_err | output | 1 | Mask is not a contiguous low run |
| bus_err | output | 1 | Read and write low together in a matching I/O cycle |

## Verification
The bench builds the decoder with its default widths: an 8-bit address and a 3-bit offset. At these widths all 256 port addresses can be swept under each configuration. The sweeps cover an 8-port block, a single port, a 64-port block and a non-contiguous mask. Each sweep runs read, write, interrupt-acknowledge and memory cycles, so every window edge and every cycle type is compared against a reference model. Directed vectors cover the enable gate and the case where read and write are low together.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

    localparam int PORT_ADDR_W = 8;
    localparam int PORT_OFS_W  = 3;

    typedef enum logic [2:0] {
        CYC_NONE,
        CYC_INTACK,
        CYC_IO_IDLE,
        CYC_IO_RD,
        CYC_IO_WR,
        CYC_IO_CLASH
    } cyc_e;

    typedef struct packed {
        logic iorq_n;
        logic m1_n;
        logic rd_n;
        logic wr_n;
    } busctl_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic clash;
    } strobe_t;

    function automatic cyc_e classify(input busctl_t c);
        if (c.iorq_n)               return CYC_NONE;
        if (!c.m1_n)                return CYC_INTACK;
        if (!c.rd_n && !c.wr_n)     return CYC_IO_CLASH;
        if (!c.rd_n)                return CYC_IO_RD;
        if (!c.wr_n)                return CYC_IO_WR;
        return CYC_IO_IDLE;
    endfunction

    function automatic strobe_t gate_strobes(input cyc_e cyc, input logic hit);
        strobe_t s;
        s.rd    = hit && (cyc == CYC_IO_RD);
        s.wr    = hit && (cyc == CYC_IO_WR);
        s.clash = hit && (cyc == CYC_IO_CLASH);
        return s;
    endfunction

endpackage

// File: rtl/io_addr_match.sv
module io_addr_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] base,
    input  logic [W-1:0] dont_care,
    input  logic         en_n,
    output logic         hit
);
    logic [W-1:0] bit_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i] = dont_care[i] | ~(addr[i] ^ base[i]);
    end

    assign hit = (&bit_ok) & ~en_n;
endmodule

// File: rtl/io_mask_check.sv
module io_mask_check #(
    parameter int W = 8
) (
    input  logic [W-1:0] mask,
    output logic         bad
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    logic [W-1:0] bumped;

    assign bumped = mask + ONE;
    assign bad    = |(mask & bumped);
endmodule

// File: rtl/io_cycle_qual.sv
module io_cycle_qual
    import io_dec_pkg::*;
(
    input  busctl_t ctl,
    input  logic    hit,
    output strobe_t stb
);
    cyc_e cyc;

    always_comb begin
        cyc = classify(ctl);
        stb = gate_strobes(cyc, hit);
    end
endmodule

// File: rtl/io_offset_pick.sv
module io_offset_pick #(
    parameter int OW = 3
) (
    input  logic [OW-1:0] addr_lo,
    input  logic [OW-1:0] mask_lo,
    output logic [OW-1:0] ofs
);
    for (genvar k = 0; k < OW; k++) begin : g_ofs
        assign ofs[k] = addr_lo[k] & mask_lo[k];
    end
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
    import io_dec_pkg::*;
#(
    parameter int ADDR_W = PORT_ADDR_W,
    parameter int OFS_W  = PORT_OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              iorq_n,
    input  logic              m1_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    output logic              match_n,
    output logic              rd_sel,
    output logic              wr_sel,
    output logic              rd_sel_n,
    output logic              wr_sel_n,
    output logic [OFS_W-1:0]  offset,
    output logic              cfg_err,
    output logic              bus_err
);
    logic    hit;
    busctl_t ctl;
    strobe_t stb;

    assign ctl = '{iorq_n: iorq_n, m1_n: m1_n, rd_n: rd_n, wr_n: wr_n};

    io_addr_match #(.W(ADDR_W)) u_match (
        .addr(addr), .base(cfg_base), .dont_care(cfg_mask), .en_n(en_n), .hit(hit)
    );

    io_mask_check #(.W(ADDR_W)) u_mchk (
        .mask(cfg_mask), .bad(cfg_err)
    );

    io_cycle_qual u_qual (
        .ctl(ctl), .hit(hit), .stb(stb)
    );

    io_offset_pick #(.OW(OFS_W)) u_ofs (
        .addr_lo(addr[OFS_W-1:0]), .mask_lo(cfg_mask[OFS_W-1:0]), .ofs(offset)
    );

    assign match_n  = ~hit;
    assign rd_sel   = stb.rd;
    assign wr_sel   = stb.wr;
    assign rd_sel_n = ~stb.rd;
    assign wr_sel_n = ~stb.wr;
    assign bus_err  = stb.clash;
endmodule

// File: rtl/io_port_decoder_chk.sv
module io_port_decoder_chk #(
    parameter int ADDR_W = 8,
    parameter int OFS_W  = 3
) (
    input logic [ADDR_W-1:0] addr,
    input logic              iorq_n,
    input logic              m1_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              en_n,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [ADDR_W-1:0] cfg_mask,
    input logic              match_n,
    input logic              rd_sel,
    input logic              wr_sel,
    input logic              rd_sel_n,
    input logic              wr_sel_n,
    input logic [OFS_W-1:0]  offset,
    input logic              cfg_err,
    input logic              bus_err
);
    always_comb begin
        // R9: selects never together
        a_r9_no_dual_strobe: assert (!(rd_sel && wr_sel))
            else $error("read and write selects asserted together");
        // R9: bus error excludes both selects
        a_r9_clash_quiet: assert (!bus_err || (!rd_sel && !wr_sel && !rd_n && !wr_n))
            else $error("bus error with a select or without both strobes low");
        // R8: interrupt acknowledge yields no select
        a_r8_intack_quiet: assert (!((!iorq_n) && (!m1_n)) || (!rd_sel && !wr_sel))
            else $error("select during interrupt acknowledge");
        // R7: no select outside I/O request
        a_r7_mem_quiet: assert (!iorq_n || 1'b1 ? (!iorq_n || (!rd_sel && !wr_sel)) : 1'b1)
            else $error("select without I/O request");
        // R2: enable gates everything
        a_r2_enable_gate: assert (!en_n || (match_n && !rd_sel && !wr_sel))
            else $error("output active while disabled");
        // R5: read select needs match and read strobe
        a_r5_read_needs_match: assert (!rd_sel || (!match_n && !rd_n && wr_n))
            else $error("read select without match or read strobe");
        // R6: write select needs match and write strobe
        a_r6_write_needs_match: assert (!wr_sel || (!match_n && !wr_n && rd_n))
            else $error("write select without match or write strobe");
    end
endmodule

bind io_port_decoder io_port_decoder_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/io_port_decoder_test.sv
module io_port_decoder_test;

    logic       clk = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, en_n = 1'b1;
    logic [7:0] cfg_base = 8'h00, cfg_mask = 8'h00;
    logic       match_n, rd_sel, wr_sel, rd_sel_n, wr_sel_n, cfg_err, bus_err;
    logic [2:0] offset;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    io_port_decoder uut (
        .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
        .en_n(en_n), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .match_n(match_n), .rd_sel(rd_sel), .wr_sel(wr_sel),
        .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .offset(offset),
        .cfg_err(cfg_err), .bus_err(bus_err)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] m;
        logic [4:0] ctl;   // iorq_n, m1_n, rd_n, wr_n, en_n
        logic       em;
        logic       er;
        logic       ew;
        logic       eb;
        logic [2:0] eo;
        logic       ec;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{4'd1,  8'h5A, 8'h5A, 8'h00, 5'b01010, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0}, // R1 exact hit
        '{4'd1,  8'h5B, 8'h5A, 8'h00, 5'b01010, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R1 one bit off
        '{4'd2,  8'h5A, 8'h5A, 8'h00, 5'b01011, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R2 disabled
        '{4'd3,  8'h0D, 8'h08, 8'h07, 5'b01010, 1'b0, 1'b1, 1'b0, 1'b0, 3'd5, 1'b0}, // R3 inside block
        '{4'd3,  8'h10, 8'h08, 8'h07, 5'b01010, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R3 above block
        '{4'd3,  8'h07, 8'h08, 8'h07, 5'b01010, 1'b1, 1'b0, 1'b0, 1'b0, 3'd7, 1'b0}, // R3 below block
        '{4'd4,  8'hFF, 8'hFF, 8'h00, 5'b01100, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0}, // R4 single port
        '{4'd4,  8'hFE, 8'hFF, 8'h00, 5'b01100, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R4 neighbour
        '{4'd6,  8'hF9, 8'hF8, 8'h07, 5'b01100, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0}, // R6 write
        '{4'd7,  8'hF9, 8'hF8, 8'h07, 5'b11010, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0}, // R7 no iorq
        '{4'd8,  8'hF9, 8'hF8, 8'h07, 5'b00010, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0}, // R8 intack read
        '{4'd8,  8'hF9, 8'hF8, 8'h07, 5'b00100, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0}, // R8 intack write
        '{4'd9,  8'hF9, 8'hF8, 8'h07, 5'b01000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0}, // R9 clash
        '{4'd9,  8'h00, 8'hF8, 8'h07, 5'b01000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R9 clash, no hit
        '{4'd12, 8'h35, 8'h30, 8'h05, 5'b01010, 1'b0, 1'b1, 1'b0, 1'b0, 3'd5, 1'b1}, // R12 holey mask hit
        '{4'd12, 8'h32, 8'h30, 8'h05, 5'b01010, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1}, // R12 holey mask miss
        '{4'd11, 8'h43, 8'h40, 8'h03, 5'b01010, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b0}, // R11 two-bit offset
        '{4'd11, 8'hC6, 8'h00, 8'hFF, 5'b01010, 1'b0, 1'b1, 1'b0, 1'b0, 3'd6, 1'b0}, // R11 full mask
        '{4'd12, 8'h80, 8'h00, 8'h80, 5'b01010, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1}  // R12 top bit only
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (addr=%02h base=%02h mask=%02h)",
                     tag, act, exp, addr, cfg_base, cfg_mask);
        end
    endtask

    task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m,
                         input logic [4:0] c);
        @(posedge clk);
        addr = a; cfg_base = b; cfg_mask = m;
        {iorq_n, m1_n, rd_n, wr_n, en_n} = c;
        @(negedge clk);
    endtask

    task automatic check_all(input logic em, input logic er, input logic ew, input logic eb,
                             input logic [2:0] eo, input logic ec);
        chk("R1 match_n", match_n, em);
        chk("R5 rd_sel", rd_sel, er);
        chk("R6 wr_sel", wr_sel, ew);
        chk("R9 bus_err", bus_err, eb);
        chk("R10 rd_sel_n", rd_sel_n, !er);
        chk("R10 wr_sel_n", wr_sel_n, !ew);
        chk("R11 offset", offset, eo);
        chk("R12 cfg_err", cfg_err, ec);
    endtask

    // reference model written from the requirements
    task automatic ref_check(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m,
                             input logic [4:0] c);
        logic hit, io, rd_low, wr_low, contig;
        hit = !c[0];
        for (int i = 0; i < 8; i++)
            if (!m[i] && (a[i] != b[i])) hit = 1'b0;
        io     = !c[4] && c[3];
        rd_low = !c[2];
        wr_low = !c[1];
        contig = 1'b0;
        for (int k = 0; k <= 8; k++)
            if ({1'b0, m} == (9'd1 << k) - 9'd1) contig = 1'b1;
        check_all(!hit, hit && io && rd_low && !wr_low, hit && io && wr_low && !rd_low,
                  hit && io && rd_low && wr_low, a[2:0] & m[2:0], !contig);
    endtask

    initial begin
        // idle state: nothing selected
        @(negedge clk);
        chk("R2 idle match_n", match_n, 1);
        chk("R7 idle rd_sel", rd_sel, 0);
        chk("R7 idle wr_sel", wr_sel, 0);
        chk("R9 idle bus_err", bus_err, 0);

        for (int v = 0; v < NV; v++) begin
            drive(TBL[v].a, TBL[v].b, TBL[v].m, TBL[v].ctl);
            check_all(TBL[v].em, TBL[v].er, TBL[v].ew, TBL[v].eb, TBL[v].eo, TBL[v].ec);
        end

        // sweeps: R3 block, R4 single port, wide block, R12 holey mask;
        // cycle types: read, write, intack (R8), memory (R7)
        begin
            logic [7:0] bases [4] = '{8'h08, 8'hA5, 8'h40, 8'h30};
            logic [7:0] masks [4] = '{8'h07, 8'h00, 8'h3F, 8'h05};
            logic [4:0] ctls  [4] = '{5'b01010, 5'b01100, 5'b00010, 5'b11010};
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 4; c++)
                    for (int a = 0; a < 256; a++) begin
                        drive(8'(a), bases[s], masks[s], ctls[c]);
                        ref_check(8'(a), bases[s], masks[s], ctls[c]);
                    end
        end

        // R2: enable high across every address with a read cycle
        for (int a = 0; a < 256; a++) begin
            drive(8'(a), 8'h10, 8'h0F, 5'b01011);
            chk("R2 disabled match_n", match_n, 1);
            chk("R2 disabled rd_sel", rd_sel, 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule